// File: doc/BRIEF.md
# Display Data Channel EDID Reader with Hot-Plug Detection

This block is a register-controlled I2C master for the monitor data channel of a display output. Software programs a 7-bit device address, a one-byte sub-address and a clock divider, then starts a combined transfer. The block writes the sub-address, issues a repeated START and reads bytes from the monitor into a 32-entry receive FIFO. It keeps reading until the FIFO is full. Software learns how many bytes are held from a count register and pops them one at a time through a data register.

When no transfer is running, the same bus can watch for a monitor being attached or removed. Two select bits arm the watch. While either is set, the block repeatedly sends the programmed address and looks at the acknowledge. It raises a connect flag on an acknowledge or a disconnect flag on a missing one, depending on which bit is armed. Probing stays off until software has launched at least one transfer after reset.

Top module: `ddc_edid_reader`

## Requirements
- R1: After reset the status register (0x28) and the FIFO count read 0, the probe interval register (0x34) reads 0x80, `irq` is low and neither bus line is pulled low.
- R2: One SCL period lasts 4 × (divider + 1) clock cycles, where the divider is the register at 0x14.
- R3: Writing 0x04 with bit 6 = 1 and bit 5 = 1 runs a combined read. The bus sees START, address byte {addr,0}, the sub-address (0x0C), a repeated START, then {addr,1}. The received bytes are read back in bus order, starting at the sub-address, from bits 7:0 of 0x24. Each read of 0x24 removes one byte.
- R4: A combined read receives bytes until the FIFO holds 32. Every byte except the final one is acknowledged, the final one is not, and a STOP follows. The count is readable in bits 7:2 of 0x30.
- R5: When a started transfer ends, status bit 0 is set.
- R6: If the address or the sub-address is not acknowledged, the transfer ends with STOP, status bits 0 and 1 are both set and the FIFO is left unchanged.
- R7: Writing 0x20 with bit 7 = 1 empties the FIFO.
- R8: Writing 0x28 with bit 4 = 1 clears status bits 0, 1, 6 and 7. No other event lowers `irq`.
- R9: Writing 0x04 with bit 6 = 1 and bit 5 = 0 sends only START, {addr,0} and STOP, and then sets status bit 0. No bytes are received.
- R10: No probing happens until a transfer has been started after reset, whatever the select register (0x38) holds.
- R11: With select bit 0 set, an acknowledged probe sets status bit 6. With select bit 1 set, an unacknowledged probe sets status bit 7. An acknowledged probe with only bit 1 set changes nothing. With select 0 the bus stays untouched.
- R12: Probes start (0x34 value) × 256 SCL periods of idle time apart.
- R13: `irq` is high exactly when status bit 0, 6 or 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the FIFO at 0x24) |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| ddc_scl_oe | output | 1 | Pull SCL low when 1 |
| ddc_sda_oe | output | 1 | Pull SDA low when 1 |
| ddc_sda_i | input | 1 | Sampled SDA line level |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several properties on every cycle. The FIFO count never exceeds its depth. The error bit never stands without the done bit. The interrupt only falls in the cycle after a clear write. Both lines stay released until the first transfer has been started. During a data or acknowledge bit, SDA does not move while SCL is high. The bench's scenarios cover the rest: the exact byte order and content against an EEPROM model on the bus, where the final NACK falls, the SCL period, the spacing between probes, and which of connect or disconnect each armed mode reports.

// File: rtl/ddc_edid_reader.sv
module ddc_edid_reader #(
  parameter int FIFO_DEPTH = 32,
  parameter int DIV_W      = 16,
  parameter logic [DIV_W-1:0] DIV_INIT = DIV_W'(124)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       reg_addr,
  input  logic [DIV_W-1:0] reg_wdata,
  input  logic             reg_we,
  input  logic             reg_re,
  output logic [DIV_W-1:0] reg_rdata,
  output logic             ddc_scl_oe,
  output logic             ddc_sda_oe,
  input  logic             ddc_sda_i,
  output logic             irq
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LASTP = PTR_W'(FIFO_DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_STOP} st_t;
  typedef enum logic [1:0] {P_AW, P_SUB, P_AR, P_DATA} seg_t;

  st_t  st;
  seg_t seg;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic             ack_r, last_r, combo_r, probe_r, poked;
  logic             done_f, err_f, conn_f, disc_f;
  logic [DIV_W-1:0] qcnt, div_r;
  logic [17:0]      ivl;
  logic [7:0]       sub_r, param_r;
  logic [6:0]       dev_r;
  logic [1:0]       sel_r, sync;
  logic [7:0]       mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] fcnt;

  wire sda_s    = sync[1];
  wire busy     = st != S_IDLE;
  wire tick     = qcnt >= div_r;
  wire sw_go    = reg_we && reg_addr == 6'h04 && reg_wdata[6] && !busy;
  wire ivl_hit  = ivl >= {param_r, 10'd0};
  wire probe_go = !busy && !sw_go && poked && sel_r != 2'b00 && ivl_hit;
  wire go       = sw_go || probe_go;
  wire op_end   = busy && tick && q == 2'd3;
  wire stop_end = op_end && st == S_STOP;
  wire clr_st   = reg_we && reg_addr == 6'h28 && reg_wdata[4];
  wire clr_fifo = reg_we && reg_addr == 6'h20 && reg_wdata[7];
  wire do_push  = op_end && st == S_RX && bitn == 4'd8 && fcnt < FULL;
  wire do_pop   = reg_re && reg_addr == 6'h24 && fcnt != '0;

  assign irq = done_f | conn_f | disc_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], ddc_sda_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sub_r <= '0; dev_r <= '0; div_r <= DIV_INIT; param_r <= 8'h80; sel_r <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        6'h0C: sub_r   <= reg_wdata[7:0];
        6'h10: dev_r   <= reg_wdata[6:0];
        6'h14: div_r   <= reg_wdata;
        6'h34: param_r <= reg_wdata[7:0];
        6'h38: sel_r   <= reg_wdata[1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      qcnt <= '0; ivl <= '0;
    end else begin
      qcnt <= (go || tick) ? '0 : qcnt + 1'b1;
      if (busy || !poked || sel_r == 2'b00) ivl <= '0;
      else if (tick && !ivl_hit)            ivl <= ivl + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_f <= 1'b0; err_f <= 1'b0; conn_f <= 1'b0; disc_f <= 1'b0;
    end else begin
      done_f <= (done_f & ~clr_st) | (stop_end & ~probe_r);
      err_f  <= (err_f  & ~clr_st) | (stop_end & ~probe_r & ~ack_r);
      conn_f <= (conn_f & ~clr_st) | (stop_end & probe_r &  ack_r & sel_r[0]);
      disc_f <= (disc_f & ~clr_st) | (stop_end & probe_r & ~ack_r & sel_r[1]);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; seg <= P_AW; q <= '0; bitn <= '0; sh <= '0;
      ack_r <= 1'b0; last_r <= 1'b0; combo_r <= 1'b0; probe_r <= 1'b0; poked <= 1'b0;
    end else if (go) begin
      st <= S_START; seg <= P_AW; q <= '0;
      combo_r <= sw_go & reg_wdata[5];
      probe_r <= probe_go;
      poked   <= 1'b1;
    end else if (busy && tick) begin
      q <= q + 1'b1;
      if (q == 2'd2) begin
        if (st == S_TX && bitn == 4'd8) ack_r <= ~sda_s;
        if (st == S_RX && bitn != 4'd8) sh <= {sh[6:0], sda_s};
      end
      if (q == 2'd3) begin
        case (st)
          S_START: begin
            st <= S_TX; bitn <= '0; sh <= {dev_r, seg == P_AR};
          end
          S_TX:
            if (bitn != 4'd8) begin
              bitn <= bitn + 1'b1; sh <= {sh[6:0], 1'b0};
            end else if (!ack_r) st <= S_STOP;
            else case (seg)
              P_AW:  if (combo_r) begin seg <= P_SUB; sh <= sub_r; bitn <= '0; end
                     else st <= S_STOP;
              P_SUB: begin seg <= P_AR; st <= S_START; end
              P_AR:  begin seg <= P_DATA; st <= S_RX; bitn <= '0; end
              default: st <= S_STOP;
            endcase
          S_RX: begin
            if (bitn == 4'd7) last_r <= fcnt >= FULL - 1'b1;
            if (bitn != 4'd8)  bitn <= bitn + 1'b1;
            else if (last_r)   st <= S_STOP;
            else               bitn <= '0;
          end
          S_STOP:  st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; fcnt <= '0;
    end else if (clr_fifo) begin
      wptr <= '0; rptr <= '0; fcnt <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LASTP) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LASTP) ? '0 : rptr + 1'b1;
      fcnt <= fcnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

  logic scl_hi, sda_hi;
  always_comb begin
    scl_hi = 1'b1;
    sda_hi = 1'b1;
    case (st)
      S_START: begin scl_hi = q == 2'd1 || q == 2'd2; sda_hi = q < 2'd2; end
      S_TX:    begin scl_hi = q == 2'd1 || q == 2'd2; sda_hi = (bitn == 4'd8) | sh[7]; end
      S_RX:    begin scl_hi = q == 2'd1 || q == 2'd2; sda_hi = (bitn != 4'd8) | last_r; end
      S_STOP:  begin scl_hi = q != 2'd0; sda_hi = q >= 2'd2; end
      default: ;
    endcase
  end
  assign ddc_scl_oe = ~scl_hi;
  assign ddc_sda_oe = ~sda_hi;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      6'h04: begin reg_rdata[6] = busy; reg_rdata[5] = combo_r; end
      6'h0C: reg_rdata[7:0] = sub_r;
      6'h10: reg_rdata[6:0] = dev_r;
      6'h14: reg_rdata = div_r;
      6'h24: reg_rdata[7:0] = mem[rptr];
      6'h28: begin
        reg_rdata[0] = done_f; reg_rdata[1] = err_f;
        reg_rdata[6] = conn_f; reg_rdata[7] = disc_f;
      end
      6'h30: reg_rdata[7:2] = 6'(fcnt);
      6'h34: reg_rdata[7:0] = param_r;
      6'h38: reg_rdata[1:0] = sel_r;
      default: ;
    endcase
  end
endmodule

// File: rtl/ddc_edid_reader_chk.sv
module ddc_edid_reader_chk #(
  parameter int FIFO_DEPTH = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             irq,
  input logic                             scl_oe,
  input logic                             sda_oe,
  input logic                             busy,
  input logic                             poked,
  input logic                             done_f,
  input logic                             err_f,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]  fcnt,
  input logic                             clr_st,
  input logic                             in_bit
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)); // R4

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_f |-> done_f); // R6

  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(busy)); // R5

  AST_IRQ_FALL_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_st)); // R8

  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !poked |-> (!scl_oe && !sda_oe)); // R10

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && $past(in_bit) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R3
endmodule

bind ddc_edid_reader ddc_edid_reader_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(ddc_scl_oe), .sda_oe(ddc_sda_oe),
  .busy(busy), .poked(poked), .done_f(done_f), .err_f(err_f), .fcnt(fcnt),
  .clr_st(clr_st), .in_bit(st == S_TX || st == S_RX)
);

// File: tb/tb_ddc_edid_reader.sv
module tb_ddc_edid_reader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [15:0] reg_rdata;
  logic        scl_oe, sda_oe, irq;
  logic        s_drive = 1'b0;
  wire         scl_w = ~scl_oe;
  wire         sda_w = ~(sda_oe | s_drive);

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_edid_reader dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .ddc_scl_oe(scl_oe), .ddc_sda_oe(sda_oe), .ddc_sda_i(sda_w), .irq(irq)
  );

  int checks = 0, failures = 0;
  bit done_rep = 0;
  bit expect_idle = 0;
  string idle_req = "R10";
  bit present = 1;
  logic [7:0] expq [$];

  function automatic logic [7:0] ee(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_rep) begin
      done_rep = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  // EEPROM-like monitor model at device address 0x50
  int cyc = 0, ss = 0, bc = 0, ptr = 0;
  logic [7:0] sh = 0, cur = 0;
  bit pscl = 1, psda = 1, rw = 0, mack = 0;
  int s_starts = 0, s_bytes = 0, s_macks = 0, s_nacks = 0;
  int s_last = 0, s_gap = 0, s_rise = 0, s_per = 0;
  logic [7:0] s_addr = 0, s_sub = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ss = 0; s_drive <= 1'b0; pscl = 1; psda = 1;
    end else begin
      if (pscl && scl_w && psda && !sda_w) begin
        ss = 1; bc = 0; sh = 0; s_drive <= 1'b0; s_starts++;
        s_gap = cyc - s_last; s_last = cyc;
      end else if (pscl && scl_w && !psda && sda_w) begin
        ss = 0; s_drive <= 1'b0;
      end else if (!pscl && scl_w) begin
        if (ss == 3 && bc >= 1 && bc <= 8) s_per = cyc - s_rise;
        s_rise = cyc;
        if (ss == 1 || ss == 2) begin
          if (bc < 8) sh = {sh[6:0], sda_w};
          bc++;
        end else if (ss == 3) begin
          if (bc == 8) mack = !sda_w;
          bc++;
        end
      end else if (pscl && !scl_w) begin
        case (ss)
          1: if (bc == 8) begin
               s_addr = sh;
               if (present && sh[7:1] == 7'h50) begin s_drive <= 1'b1; rw = sh[0]; end
               else ss = 4;
             end else if (bc == 9) begin
               if (rw) begin ss = 3; bc = 0; cur = ee(ptr); s_drive <= !cur[7]; end
               else begin ss = 2; bc = 0; sh = 0; s_drive <= 1'b0; end
             end
          2: if (bc == 8) s_drive <= 1'b1;
             else if (bc == 9) begin s_drive <= 1'b0; ptr = sh; s_sub = sh; ss = 4; end
          3: if (bc < 8) s_drive <= !cur[7 - bc];
             else if (bc == 8) s_drive <= 1'b0;
             else begin
               s_bytes++;
               if (mack) begin
                 s_macks++; ptr = (ptr + 1) & 255; cur = ee(ptr); bc = 0; s_drive <= !cur[7];
               end else begin
                 s_nacks++; ss = 4; s_drive <= 1'b0;
               end
             end
          default: ;
        endcase
      end
      pscl = scl_w; psda = sda_w;
    end
  end

  // Per-clock reference: bus must stay released while the model expects no activity
  always @(negedge clk) begin
    if (expect_idle) begin
      checks++;
      if (scl_oe || sda_oe) begin
        failures++;
        $display("FAIL %s actual=%0b%0b expected=00 (bus driven while idle)", idle_req, scl_oe, sda_oe);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic wait_irq(input string req, input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    chk(req, irq, 1);
  endtask

  task automatic idle_window(input string req, input int n);
    idle_req = req; expect_idle = 1;
    repeat (n) @(negedge clk);
    expect_idle = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int b0, m0, n0, st0, g;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", irq, 0);
    chk("R1", {scl_oe, sda_oe}, 0);
    rd(6'h28, d); chk("R1", d, 0);
    rd(6'h30, d); chk("R1", d, 0);
    rd(6'h34, d); chk("R1", d, 16'h0080);

    // R10 no probing before the first transfer, even when armed
    wr(6'h14, 16'd3); wr(6'h10, 16'h50); wr(6'h34, 16'd1); wr(6'h38, 16'd1);
    idle_window("R10", 6000);
    rd(6'h28, d); chk("R10", d, 0);
    wr(6'h38, 16'd0);

    // R9 address-only transfer
    b0 = s_bytes;
    wr(6'h04, 16'h0040);
    wait_irq("R9", 20000);
    rd(6'h28, d); chk("R9", d, 16'h0001);
    rd(6'h30, d); chk("R9", d, 0);
    chk("R9", s_addr, 8'hA0);
    chk("R9", s_bytes - b0, 0);
    wr(6'h28, 16'h0010);
    rd(6'h28, d); chk("R8", d, 0);
    chk("R8", irq, 0);

    // R3 R4 R2 combined read into an empty FIFO
    wr(6'h0C, 16'h10); wr(6'h20, 16'h80);
    b0 = s_bytes; m0 = s_macks; n0 = s_nacks; st0 = s_starts;
    wr(6'h04, 16'h0060);
    wait_irq("R5", 20000);
    rd(6'h28, d); chk("R5", d, 16'h0001);
    chk("R13", irq, 1);
    rd(6'h30, d); chk("R4", d[7:2], 32);
    chk("R4", s_bytes - b0, 32);
    chk("R4", s_macks - m0, 31);
    chk("R4", s_nacks - n0, 1);
    chk("R3", s_starts - st0, 2);
    chk("R3", s_sub, 8'h10);
    chk("R3", s_addr, 8'hA1);
    chk("R2", s_per, 16);
    for (int i = 0; i < 32; i++) expq.push_back(ee(16 + i));
    for (int i = 0; i < 32; i++) begin
      rd(6'h24, d); chk("R3", d[7:0], expq.pop_front());
    end
    rd(6'h30, d); chk("R3", d[7:2], 0);
    wr(6'h28, 16'h0010);
    chk("R13", irq, 0);

    // R4 read stops when FIFO fills from a partly filled state
    wr(6'h0C, 16'h00);
    wr(6'h04, 16'h0060);
    wait_irq("R4", 20000);
    for (int i = 0; i < 32; i++) expq.push_back(ee(i));
    for (int i = 0; i < 5; i++) begin
      rd(6'h24, d); chk("R3", d[7:0], expq.pop_front());
    end
    wr(6'h28, 16'h0010);
    wr(6'h0C, 16'h80);
    b0 = s_bytes;
    wr(6'h04, 16'h0060);
    wait_irq("R4", 20000);
    chk("R4", s_bytes - b0, 5);
    rd(6'h30, d); chk("R4", d[7:2], 32);
    for (int i = 0; i < 5; i++) expq.push_back(ee(128 + i));
    for (int i = 0; i < 3; i++) begin
      rd(6'h24, d); chk("R3", d[7:0], expq.pop_front());
    end

    // R7 FIFO clear
    wr(6'h20, 16'h80);
    expq.delete();
    rd(6'h30, d); chk("R7", d[7:2], 0);
    wr(6'h28, 16'h0010);

    // R6 address not acknowledged
    wr(6'h10, 16'h51);
    b0 = s_bytes;
    wr(6'h04, 16'h0060);
    wait_irq("R6", 20000);
    rd(6'h28, d); chk("R6", d, 16'h0003);
    rd(6'h30, d); chk("R6", d[7:2], 0);
    chk("R6", s_bytes - b0, 0);
    chk("R6", {scl_oe, sda_oe}, 0);
    wr(6'h28, 16'h0010);
    chk("R8", irq, 0);

    // R11 R12 plug detection
    wr(6'h10, 16'h50); present = 1;
    wr(6'h38, 16'd1);
    wait_irq("R11", 20000);
    rd(6'h28, d); chk("R11", d, 16'h0040);
    chk("R13", irq, 1);
    wr(6'h28, 16'h0010);
    st0 = s_starts;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (s_starts != st0) break;
    end
    g = s_gap;
    chk("R12", (g >= 4096 && g <= 4096 + 400), 1);

    // R11 removal watch: acknowledged probe reports nothing, missing one reports disconnect
    wr(6'h38, 16'd2);
    repeat (300) @(negedge clk);
    wr(6'h28, 16'h0010);
    repeat (10000) @(negedge clk);
    rd(6'h28, d); chk("R11", d, 0);
    present = 0;
    wait_irq("R11", 20000);
    rd(6'h28, d); chk("R11", d, 16'h0080);
    chk("R13", irq, 1);
    wr(6'h38, 16'd0);
    repeat (600) @(negedge clk);
    wr(6'h28, 16'h0010);
    idle_window("R11", 6000);
    rd(6'h28, d); chk("R11", d, 0);
    chk("R13", irq, 0);

    summary();
    $finish;
  end
endmodule